// File: doc/BRIEF.md
# Line-Doubling VGA Framebuffer Scanout

This block turns a packed-pixel image held in an external dual-port video RAM into a 640x480 VGA raster. The stored image is 640 pixels wide and 200 rows tall. Every stored row is sent on two consecutive display lines, so the picture fills the top 400 lines of the screen. Everything outside the picture is driven black.

The block runs from a single 100 MHz system clock. A one-in-four enable stands in for a 25 MHz pixel clock. The horizontal and vertical counters and all video outputs move only on that enable. A parameter selects the pixel format: one byte per pixel (3-3-2) or two bytes per pixel (5-6-5). Either format is reduced to 4-bit red, green and blue channels. Horizontal and vertical sync are active low.

A byte-wide write port lets a bus slave fill the video RAM. Each write is turned into a registered, lane-enabled write to a RAM whose word holds exactly one pixel. The scanout side presents a pixel-indexed read address and expects the data one clock later.

Top module: `vga_line_dbl_scanout`

## Requirements
- R1: While rst_ni is low, vga_hs_o and vga_vs_o are 1, all colour outputs are 0, and the raster position and enable divider are cleared to horizontal 0, line 0.
- R2: The pixel enable fires on every fourth rising clock edge, the first time on the fourth edge after reset is released. The video outputs change only on those edges. The values taken on the k-th enable edge belong to raster position k-1, counted horizontal-first.
- R3: With one byte per pixel, red is taken from data bits 2:0, green from bits 5:3 and blue from bits 7:6. Each field lands in the top bits of its 4-bit output, and the unused low output bits are 0.
- R4: With two bytes per pixel, red output = data[15:12], green output = data[10:7] and blue output = data[4:1].
- R5: ram_raddr_o carries the pixel index (line / LINE_REP) * IMG_W + horizontal. The RAM returns that word one clock later, and one RAM word is one pixel.
- R6: Display lines 2k and 2k+1 both show stored row k.
- R7: Colour outputs are 0 whenever horizontal >= IMG_W or line >= IMG_ROWS*LINE_REP. This covers display lines 400..479 and both blanking periods.
- R8: A line lasts H_VIS+H_FP+H_SYNC+H_BP enables (640+16+96+48 by default). vga_hs_o is 0 exactly for horizontal positions H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1.
- R9: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (480+10+2+33 by default). vga_vs_o is 0 exactly for lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1. After the last position the raster restarts at horizontal 0, line 0.
- R10: When wr_en_i is sampled high, the next cycle gives ram_we_o = 1. It also gives ram_waddr_o = byte address / BPP and ram_wdata_o = the data byte repeated in every lane. ram_wbe_o is one-hot on lane (byte address mod BPP), where lane 0 is bits 7:0. Only the low log2(IMG_W*IMG_ROWS*BPP) address bits are used: 17 bits for one byte per pixel and 18 bits for two. When wr_en_i is low, ram_we_o is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe from the bus slave |
| wr_addr_i | input | 32 | Byte address (low bits used) |
| wr_data_i | input | 8 | Write data byte |
| ram_we_o | output | 1 | Video RAM write enable |
| ram_wbe_o | output | 1 (BPP) | Video RAM byte-lane enables |
| ram_waddr_o | output | 17 | Video RAM write pixel index |
| ram_wdata_o | output | 8 (8*BPP) | Video RAM write word |
| ram_raddr_o | output | 17 | Video RAM read pixel index |
| ram_rdata_i | input | 8 (8*BPP) | Video RAM read word, one clock after the address |
| vga_r_o | output | 4 | Red |
| vga_g_o | output | 4 | Green |
| vga_b_o | output | 4 | Blue |
| vga_hs_o | output | 1 | Horizontal sync, active low |
| vga_vs_o | output | 1 | Vertical sync, active low |

## Verification
The colour and sync values for raster position n (horizontal-first, counted from reset release) are registered on rising edge 4(n+1) and hold until edge 4(n+2). The bench counts edges from reset release and samples each expected position on the falling edge right after edge 4(n+1). It also looks one edge earlier to confirm that nothing moves between enables. Write-port outputs are due one edge after the strobe and are sampled on the following falling edge. Pixels changed through the write port are checked in the next frame, against values the bench predicts from the written bytes. The bench uses a shrunken raster, so that whole frames, both syncs and the frame wrap fit in a short run.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  typedef struct packed {
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
  } rgb12_t;

  localparam rgb12_t RGB_BLACK = '{r: 4'h0, g: 4'h0, b: 4'h0};
endpackage

// File: rtl/vga_pix_div.sv
module vga_pix_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pix_en_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign pix_en_o = (cnt_q == LAST);
endmodule

// File: rtl/vga_axis_cnt.sv
// One raster axis: position counter with wrap, sync window and picture window.
module vga_axis_cnt #(
  parameter int VIS  = 640,
  parameter int FP   = 16,
  parameter int SYNC = 96,
  parameter int BP   = 48,
  parameter int ACT  = 640,
  localparam int TOT = VIS + FP + SYNC + BP,
  localparam int W   = $clog2(TOT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         sync_o,
  output logic         act_o
);
  localparam logic [W-1:0] LAST   = W'(TOT - 1);
  localparam logic [W-1:0] S_BEG  = W'(VIS + FP);
  localparam logic [W-1:0] S_END  = W'(VIS + FP + SYNC);
  localparam logic [W-1:0] ACT_LIM = W'(ACT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (step_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == LAST);
  assign sync_o = (cnt_q >= S_BEG) && (cnt_q < S_END);
  assign act_o  = (cnt_q < ACT_LIM);
endmodule

// File: rtl/vga_pix_fmt.sv
// Colour expansion and output registers, updated on pixel enable only.
module vga_pix_fmt
  import vga_scan_pkg::*;
#(
  parameter int BPP = 1,
  localparam int PW = 8 * BPP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          act_i,
  input  logic          hs_act_i,
  input  logic          vs_act_i,
  input  logic [PW-1:0] rdata_i,
  output logic [3:0]    r_o,
  output logic [3:0]    g_o,
  output logic [3:0]    b_o,
  output logic          hs_o,
  output logic          vs_o
);
  rgb12_t pix_d, rgb_q;

  generate
    if (BPP == 1) begin : g_332
      assign pix_d.r = {rdata_i[2:0], 1'b0};
      assign pix_d.g = {rdata_i[5:3], 1'b0};
      assign pix_d.b = {rdata_i[7:6], 2'b00};
    end else begin : g_565
      logic unused_lsbs;
      assign pix_d.r = rdata_i[15:12];
      assign pix_d.g = rdata_i[10:7];
      assign pix_d.b = rdata_i[4:1];
      assign unused_lsbs = rdata_i[11] ^ rdata_i[6] ^ rdata_i[0] ^ (^rdata_i[PW-1:16-PW+16-1+1-16+15]);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_q <= RGB_BLACK;
      hs_o  <= 1'b1;
      vs_o  <= 1'b1;
    end else if (pix_en_i) begin
      rgb_q <= act_i ? pix_d : RGB_BLACK;
      hs_o  <= ~hs_act_i;
      vs_o  <= ~vs_act_i;
    end
  end

  assign r_o = rgb_q.r;
  assign g_o = rgb_q.g;
  assign b_o = rgb_q.b;
endmodule

// File: rtl/vga_wr_port.sv
// Byte write to pixel-wide RAM: lane select, replicated data, one register stage.
module vga_wr_port #(
  parameter int BPP    = 1,
  parameter int BUS_AW = 32,
  parameter int PIX_AW = 17,
  localparam int OFFS    = $clog2(BPP),
  localparam int BYTE_AW = PIX_AW + OFFS,
  localparam int LW      = (BPP > 1) ? OFFS : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BUS_AW-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  output logic               we_o,
  output logic [BPP-1:0]     wbe_o,
  output logic [PIX_AW-1:0]  waddr_o,
  output logic [8*BPP-1:0]   wdata_o
);
  logic [BYTE_AW-1:0] byte_a;
  logic [LW-1:0]      lane;
  logic               unused_hi;

  assign byte_a    = wr_addr_i[BYTE_AW-1:0];
  assign unused_hi = ^wr_addr_i[BUS_AW-1:BYTE_AW];

  generate
    if (BPP > 1) begin : g_lane
      assign lane = byte_a[LW-1:0];
    end else begin : g_nolane
      assign lane = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      wbe_o   <= '0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= wr_en_i;
      if (wr_en_i) begin
        wbe_o   <= BPP'(1) << lane;
        waddr_o <= PIX_AW'(byte_a >> OFFS);
        wdata_o <= {BPP{wr_data_i}};
      end
    end
  end
endmodule

// File: rtl/vga_line_dbl_scanout.sv
module vga_line_dbl_scanout #(
  parameter int BPP      = 1,
  parameter int BUS_AW   = 32,
  parameter int IMG_W    = 640,
  parameter int IMG_ROWS = 200,
  parameter int LINE_REP = 2,
  parameter int CLK_DIV  = 4,
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  localparam int PIX_AW  = $clog2(IMG_W * IMG_ROWS),
  localparam int PW      = 8 * BPP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BUS_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              ram_we_o,
  output logic [BPP-1:0]    ram_wbe_o,
  output logic [PIX_AW-1:0] ram_waddr_o,
  output logic [PW-1:0]     ram_wdata_o,
  output logic [PIX_AW-1:0] ram_raddr_o,
  input  logic [PW-1:0]     ram_rdata_i,
  output logic [3:0]        vga_r_o,
  output logic [3:0]        vga_g_o,
  output logic [3:0]        vga_b_o,
  output logic              vga_hs_o,
  output logic              vga_vs_o
);
  localparam int HW = $clog2(H_VIS + H_FP + H_SYNC + H_BP);
  localparam int VW = $clog2(V_VIS + V_FP + V_SYNC + V_BP);
  localparam logic [VW-1:0]     REP_V = VW'(LINE_REP);
  localparam logic [PIX_AW-1:0] W_A   = PIX_AW'(IMG_W);

  logic          pix_en;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_wrap, v_wrap, h_sync, v_sync, h_act, v_act, img_act;
  logic [VW-1:0] row;
  logic          unused_vwrap;

  vga_pix_div #(.DIV(CLK_DIV)) u_div (
    .clk_i, .rst_ni, .pix_en_o(pix_en)
  );

  vga_axis_cnt #(
    .VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP), .ACT(IMG_W)
  ) u_hcnt (
    .clk_i, .rst_ni, .step_i(pix_en),
    .cnt_o(h_cnt), .wrap_o(h_wrap), .sync_o(h_sync), .act_o(h_act)
  );

  vga_axis_cnt #(
    .VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP), .ACT(IMG_ROWS * LINE_REP)
  ) u_vcnt (
    .clk_i, .rst_ni, .step_i(pix_en & h_wrap),
    .cnt_o(v_cnt), .wrap_o(v_wrap), .sync_o(v_sync), .act_o(v_act)
  );

  assign unused_vwrap = v_wrap;
  assign img_act = h_act & v_act;
  assign row     = v_cnt / REP_V;

  // Counters are stable for the whole enable period; RAM samples this a cycle early.
  assign ram_raddr_o = img_act ? (PIX_AW'(row) * W_A + PIX_AW'(h_cnt)) : '0;

  vga_pix_fmt #(.BPP(BPP)) u_fmt (
    .clk_i, .rst_ni, .pix_en_i(pix_en), .act_i(img_act),
    .hs_act_i(h_sync), .vs_act_i(v_sync), .rdata_i(ram_rdata_i),
    .r_o(vga_r_o), .g_o(vga_g_o), .b_o(vga_b_o),
    .hs_o(vga_hs_o), .vs_o(vga_vs_o)
  );

  vga_wr_port #(.BPP(BPP), .BUS_AW(BUS_AW), .PIX_AW(PIX_AW)) u_wr (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .we_o(ram_we_o), .wbe_o(ram_wbe_o), .waddr_o(ram_waddr_o), .wdata_o(ram_wdata_o)
  );
endmodule

// File: rtl/vga_scan_chk.sv
module vga_scan_chk #(
  parameter int IMG_W    = 640,
  parameter int IMG_ROWS = 200,
  parameter int LINE_REP = 2,
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int HW       = 10,
  parameter int VW       = 10,
  parameter int PIX_AW   = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_en,
  input logic [HW-1:0]     h_cnt,
  input logic [VW-1:0]     v_cnt,
  input logic              wr_en_i,
  input logic              ram_we_o,
  input logic [PIX_AW-1:0] ram_raddr_o,
  input logic [3:0]        vga_r_o,
  input logic [3:0]        vga_g_o,
  input logic [3:0]        vga_b_o,
  input logic              vga_hs_o,
  input logic              vga_vs_o
);
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam logic [HW-1:0] H_LAST = HW'(HT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(VT - 1);
  localparam logic [HW-1:0] HS_B = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_E = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_B = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_E = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [HW-1:0] H_IMG = HW'(IMG_W);
  localparam logic [VW-1:0] V_IMG = VW'(IMG_ROWS * LINE_REP);
  localparam logic [PIX_AW-1:0] N_PIX = PIX_AW'(IMG_W * IMG_ROWS);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (vga_hs_o && vga_vs_o && {vga_r_o, vga_g_o, vga_b_o} == 12'h0)
        else $error("reset outputs not idle");
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en |=> $stable({vga_r_o, vga_g_o, vga_b_o, vga_hs_o, vga_vs_o}));

  p_en_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en |=> !pix_en);

  p_raddr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_raddr_o < N_PIX);

  p_blank_black_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en && (h_cnt >= H_IMG || v_cnt >= V_IMG) |=> {vga_r_o, vga_g_o, vga_b_o} == 12'h0);

  p_hsync_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en && h_cnt >= HS_B && h_cnt < HS_E |=> !vga_hs_o);

  p_hsync_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en && (h_cnt < HS_B || h_cnt >= HS_E) |=> vga_hs_o);

  p_vsync_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en && v_cnt >= VS_B && v_cnt < VS_E |=> !vga_vs_o);

  p_frame_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en && h_cnt == H_LAST && v_cnt == V_LAST |=> h_cnt == '0 && v_cnt == '0);

  p_write_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ram_we_o);

  p_write_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !ram_we_o);
endmodule

bind vga_line_dbl_scanout vga_scan_chk #(
  .IMG_W(IMG_W), .IMG_ROWS(IMG_ROWS), .LINE_REP(LINE_REP),
  .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
  .HW(HW), .VW(VW), .PIX_AW(PIX_AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_en(pix_en), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .wr_en_i(wr_en_i), .ram_we_o(ram_we_o), .ram_raddr_o(ram_raddr_o),
  .vga_r_o(vga_r_o), .vga_g_o(vga_g_o), .vga_b_o(vga_b_o),
  .vga_hs_o(vga_hs_o), .vga_vs_o(vga_vs_o)
);

// File: tb/vga_line_dbl_scanout_test.sv
module vga_line_dbl_scanout_test;
  // Shrunken raster: 24 x 17 positions, picture 16 x 5 rows doubled to 10 lines.
  localparam int IW = 16, IR = 5;
  localparam int HV = 16, HF = 2, HS = 3, HB = 3, HT = HV + HF + HS + HB;
  localparam int VV = 12, VF = 1, VS = 2, VB = 2, VT = VV + VF + VS + VB;
  localparam int FRAME = HT * VT;
  localparam int AW = $clog2(IW * IR);
  localparam int NPIX = IW * IR;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cnt = 0;

  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;

  logic           we1, we2;
  logic [0:0]     wbe1;
  logic [1:0]     wbe2;
  logic [AW-1:0]  wa1, wa2, ra1, ra2;
  logic [7:0]     wd1, rd1;
  logic [15:0]    wd2, rd2;
  logic [3:0]     r1, g1, b1, r2, g2, b2;
  logic           hs1, vs1, hs2, vs2;

  logic [7:0]  mem8  [NPIX];
  logic [15:0] mem16 [NPIX];
  logic [7:0]  gold8 [NPIX];
  logic [15:0] gold16 [NPIX];

  vga_line_dbl_scanout #(
    .BPP(1), .IMG_W(IW), .IMG_ROWS(IR), .LINE_REP(2), .CLK_DIV(4),
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ram_we_o(we1), .ram_wbe_o(wbe1), .ram_waddr_o(wa1), .ram_wdata_o(wd1),
    .ram_raddr_o(ra1), .ram_rdata_i(rd1),
    .vga_r_o(r1), .vga_g_o(g1), .vga_b_o(b1), .vga_hs_o(hs1), .vga_vs_o(vs1)
  );

  vga_line_dbl_scanout #(
    .BPP(2), .IMG_W(IW), .IMG_ROWS(IR), .LINE_REP(2), .CLK_DIV(4),
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ram_we_o(we2), .ram_wbe_o(wbe2), .ram_waddr_o(wa2), .ram_wdata_o(wd2),
    .ram_raddr_o(ra2), .ram_rdata_i(rd2),
    .vga_r_o(r2), .vga_g_o(g2), .vga_b_o(b2), .vga_hs_o(hs2), .vga_vs_o(vs2)
  );

  // Video RAM models, one-clock read latency.
  always @(posedge clk) begin
    if (we1 && wbe1[0]) mem8[wa1] <= wd1;
    if (we2 && wbe2[0]) mem16[wa2][7:0]  <= wd2[7:0];
    if (we2 && wbe2[1]) mem16[wa2][15:8] <= wd2[15:8];
    rd1 <= mem8[ra1];
    rd2 <= mem16[ra2];
  end

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else        cnt <= cnt + 1;
  end

  function automatic logic [11:0] e332(input logic [7:0] d);
    return {d[2:0], 1'b0, d[5:3], 1'b0, d[7:6], 2'b00};
  endfunction

  function automatic logic [11:0] e565(input logic [15:0] d);
    return {d[15:12], d[10:7], d[4:1]};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", req, what, act, exp, cnt);
    end
  endtask

  task automatic wait_cnt(input int target);
    while (cnt != target) @(negedge clk);
  endtask

  // Sample position n (frame-relative index f*FRAME + v*HT + h) after its enable edge.
  task automatic chk_pos(input string req, input int f, input int h, input int v);
    logic [11:0] x1, x2;
    int idx;
    wait_cnt(4 * (f * FRAME + v * HT + h + 1));
    if (h < IW && v < 2 * IR) begin
      idx = (v / 2) * IW + h;
      x1 = e332(gold8[idx]);
      x2 = e565(gold16[idx]);
    end else begin
      x1 = '0;
      x2 = '0;
    end
    chk(req, "rgb332", {4'h0, r1, g1, b1}, {4'h0, x1});
    chk(req, "rgb565", {4'h0, r2, g2, b2}, {4'h0, x2});
    chk("R8", "hsync", {15'h0, hs1}, {15'h0, !(h >= HV + HF && h < HV + HF + HS)});
    chk("R9", "vsync", {15'h0, vs2}, {15'h0, !(v >= VV + VF && v < VV + VF + VS)});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "hs in reset", {15'h0, hs1}, 16'h1);
    chk("R1", "vs in reset", {15'h0, vs2}, 16'h1);
    chk("R1", "rgb in reset", {4'h0, r1, g1, b1}, 16'h0);
    chk("R1", "rgb565 in reset", {4'h0, r2, g2, b2}, 16'h0);
    rst_n = 1'b1;
    wait_cnt(3);
    chk("R2", "rgb before first enable", {4'h0, r1, g1, b1}, 16'h0);
    chk("R2", "rgb565 before first enable", {4'h0, r2, g2, b2}, 16'h0);
  endtask

  task automatic t_row0;
    for (int h = 0; h < IW; h++) chk_pos("R3 R4 R5 R2", 0, h, 0);
  endtask

  task automatic t_hblank;
    for (int h = IW; h < HT; h++) chk_pos("R7 R8", 0, h, 0);
  endtask

  task automatic t_doubling;
    for (int v = 1; v < VV; v++)
      for (int h = 0; h < HT; h += (v < 2 * IR ? 1 : 5)) chk_pos("R6 R7", 0, h, v);
  endtask

  task automatic t_vsync;
    for (int v = VV; v < VT; v++) begin
      chk_pos("R9 R7", 0, 0, v);
      chk_pos("R9 R8", 0, HV + HF, v);
    end
  endtask

  task automatic t_write;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 32'hFFFF_FF85; wr_data = 8'hC9;
    @(negedge clk);
    chk("R10", "we", {15'h0, we1}, 16'h1);
    chk("R10", "waddr332", {9'h0, wa1}, 16'd5);
    chk("R10", "wbe332", {15'h0, wbe1}, 16'h1);
    chk("R10", "wdata332", {8'h0, wd1}, 16'h00C9);
    chk("R10", "waddr565", {9'h0, wa2}, 16'd66);
    chk("R10", "wbe565", {14'h0, wbe2}, 16'h2);
    chk("R10", "wdata565", wd2, 16'hC9C9);
    wr_addr = 32'hFFFF_FF84; wr_data = 8'h3C;
    @(negedge clk);
    chk("R10", "waddr332 b", {9'h0, wa1}, 16'd4);
    chk("R10", "wbe565 b", {14'h0, wbe2}, 16'h1);
    chk("R10", "wdata565 b", wd2, 16'h3C3C);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R10", "we idle", {14'h0, we1, we2}, 16'h0);
    gold8[5]   = 8'hC9;
    gold8[4]   = 8'h3C;
    gold16[66] = 16'hC93C;
  endtask

  task automatic t_frame2;
    chk_pos("R9 wrap", 1, 0, 0);
    chk_pos("R10 written", 1, 4, 0);
    chk_pos("R10 written", 1, 5, 0);
    chk_pos("R10 R6 written", 1, 2, 8);
    chk_pos("R10 R6 written", 1, 2, 9);
  endtask

  initial begin
    for (int i = 0; i < NPIX; i++) begin
      gold8[i]  = 8'(i * 37 + 11);
      gold16[i] = 16'(i * 1234 + 4321);
      mem8[i]   = gold8[i];
      mem16[i]  = gold16[i];
    end
    #1 rst_n = 1'b0;
    t_reset();
    t_row0();
    t_hblank();
    t_doubling();
    t_vsync();
    t_write();
    t_frame2();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule